// File: doc/BRIEF.md
# Phase-Frequency Detector with Lock Indicator

This block compares two divided clock streams, one derived from a VCO and one from a reference, and produces a coarse three-state correction. The correction is modelled as three signals: a pump-up request, a pump-down request and a drive enable. When the drive enable is low, the correction pad is taken to be in high impedance. Both streams are sampled by a faster system clock. The block measures the phase error between matching rising edges of the two streams in system-clock cycles.

A lock indicator, active low, is driven when the measured error has stayed inside a programmable window for several comparisons in a row. While lock holds, the correction is released to high impedance instead of producing narrow pulses. The analog fine detector, the charge pump and the open-drain pad are outside this block.

Top module: `pfd_lock_detect`

## Requirements
- R1: Each stream passes through a two-flop synchroniser and a rising-edge detector. When the VCO edge leads the reference edge by d system-clock cycles (after synchronisation), pump_up is high for d+1 consecutive cycles and pump_dn for 1 cycle, in each comparison.
- R2: When the reference edge leads by d cycles, pump_dn is high for d+1 cycles and pump_up for 1 cycle, in each comparison.
- R3: pump_up and pump_dn are never both high on two consecutive cycles. When both are high, both clear on the next clock.
- R4: The phase error of a comparison is the number of system-clock cycles between the two synchronised rising edges. It is inside the window when it is less than or equal to the 4-bit unsigned value on lock_win (0 to 15).
- R5: lock_n goes low on the cycle after the fourth consecutive in-window comparison. After three such comparisons it is still high.
- R6: A single comparison outside the window releases lock_n (high) at once. The release also happens while one edge is still pending, as soon as its wait exceeds the window. The consecutive count then restarts from zero.
- R7: drive_en is high exactly when pump_up or pump_dn is high and lock is not held. While lock_n is low, drive_en stays low.
- R8: While rst is high, and on the cycle after it, pump_up, pump_dn and drive_en are low and lock_n is high.
- R9: If only the VCO stream toggles, pump_up stays high, pump_dn stays low and lock_n stays high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock for sampling and measuring |
| rst | input | 1 | Synchronous reset, active high |
| vco_div | input | 1 | Divided VCO clock, asynchronous |
| ref_div | input | 1 | Divided reference clock, asynchronous |
| lock_win | input | 4 | Lock window width in system-clock cycles |
| pump_up | output | 1 | Positive correction request |
| pump_dn | output | 1 | Negative correction request |
| drive_en | output | 1 | Correction driven when high, high impedance when low |
| lock_n | output | 1 | Lock flag, low while locked, high when released |

## Verification
The bench builds the block with its default parameters: two synchroniser stages, a lock run of four and an 8-bit error counter. These values make every window setting from 0 to 15 reachable. The bench sweeps every window against offsets from 0 to 17 cycles in both lead directions. That covers both sides of each window edge, the zero-offset case where both edges coincide, and early release while an edge is still pending. Separate runs check that one outlying comparison breaks an established lock and restarts the count, and what happens when only one stream toggles.

// File: rtl/pfd_pkg.sv
package pfd_pkg;

    localparam int SYNC_STAGES = 2;
    localparam int LOCK_RUNS   = 4;
    localparam int WIN_W       = 4;
    localparam int ERR_W       = 8;

    // Result of one cycle of phase measurement.
    typedef struct packed {
        logic hit;   // comparison finished inside the window
        logic miss;  // comparison outside, or pending edge waited too long
    } cmp_t;

    typedef enum logic [1:0] {
        PH_IDLE   = 2'b00,
        PH_UP     = 2'b01,
        PH_DN     = 2'b10,
        PH_BOTH   = 2'b11
    } pump_state_e;

    function automatic logic [ERR_W-1:0] sat_inc(input logic [ERR_W-1:0] v);
        return (&v) ? v : v + 1'b1;
    endfunction

endpackage

// File: rtl/pfd_edge_sync.sv
module pfd_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic din,
    output logic rise
);
    // STAGES synchroniser flops plus one history flop for edge detection.
    logic [STAGES:0] sh;

    always_ff @(posedge clk) begin
        if (rst) sh <= '0;
        else     sh <= {sh[STAGES-1:0], din};
    end

    assign rise = sh[STAGES-1] & ~sh[STAGES];
endmodule

// File: rtl/pfd_phase_meter.sv
module pfd_phase_meter
    import pfd_pkg::*;
#(
    parameter int CW = ERR_W,
    parameter int WW = WIN_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          up,
    input  logic          dn,
    input  logic [WW-1:0] win,
    output cmp_t          res
);
    logic [CW-1:0] cnt;
    logic [CW-1:0] win_x;
    logic          single;
    logic          both;

    assign single = up ^ dn;
    assign both   = up & dn;
    assign win_x  = CW'(win);

    // Count cycles where exactly one pump is pending; clear otherwise.
    always_ff @(posedge clk) begin
        if (rst)         cnt <= '0;
        else if (single) cnt <= sat_inc(cnt);
        else             cnt <= '0;
    end

    always_comb begin
        res.hit  = both && (cnt <= win_x);
        res.miss = (both && (cnt > win_x)) || (single && (cnt >= win_x));
    end
endmodule

// File: rtl/pfd_lock_filter.sv
module pfd_lock_filter
    import pfd_pkg::*;
#(
    parameter int RUNS = LOCK_RUNS
) (
    input  logic clk,
    input  logic rst,
    input  cmp_t res,
    output logic locked
);
    localparam int SW = $clog2(RUNS + 1);
    localparam logic [SW-1:0] RUN_MAX = SW'(RUNS);

    logic [SW-1:0] streak;
    logic [SW-1:0] streak_nx;

    always_comb begin
        streak_nx = streak;
        if (res.miss)
            streak_nx = '0;
        else if (res.hit && (streak != RUN_MAX))
            streak_nx = streak + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            streak <= '0;
            locked <= 1'b0;
        end else begin
            streak <= streak_nx;
            locked <= (streak_nx == RUN_MAX);
        end
    end
endmodule

// File: rtl/pfd_lock_detect.sv
module pfd_lock_detect
    import pfd_pkg::*;
#(
    parameter int STAGES = SYNC_STAGES,
    parameter int RUNS   = LOCK_RUNS,
    parameter int WW     = WIN_W,
    parameter int CW     = ERR_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          vco_div,
    input  logic          ref_div,
    input  logic [WW-1:0] lock_win,
    output logic          pump_up,
    output logic          pump_dn,
    output logic          drive_en,
    output logic          lock_n
);
    logic [1:0]  rise;
    logic [1:0]  raw_in;
    pump_state_e pst;
    cmp_t        res;
    logic        locked;

    assign raw_in = {ref_div, vco_div};

    // One synchroniser per stream: index 0 is VCO, index 1 is reference.
    for (genvar g = 0; g < 2; g++) begin : g_sync
        pfd_edge_sync #(.STAGES(STAGES)) u_sync (
            .clk  (clk),
            .rst  (rst),
            .din  (raw_in[g]),
            .rise (rise[g])
        );
    end

    // Pump flip-flops: set by edges, both cleared once both are set.
    always_ff @(posedge clk) begin
        if (rst)
            pst <= PH_IDLE;
        else if (pst == PH_BOTH)
            pst <= pump_state_e'({rise[1], rise[0]});
        else
            pst <= pump_state_e'(pst | {rise[1], rise[0]});
    end

    assign pump_up = pst[0];
    assign pump_dn = pst[1];

    pfd_phase_meter #(.CW(CW), .WW(WW)) u_meter (
        .clk (clk),
        .rst (rst),
        .up  (pump_up),
        .dn  (pump_dn),
        .win (lock_win),
        .res (res)
    );

    pfd_lock_filter #(.RUNS(RUNS)) u_lock (
        .clk    (clk),
        .rst    (rst),
        .res    (res),
        .locked (locked)
    );

    assign drive_en = (pump_up | pump_dn) & ~locked;
    assign lock_n   = ~locked;
endmodule

// File: rtl/pfd_lock_detect_chk.sv
module pfd_lock_detect_chk (
    input logic clk,
    input logic rst,
    input logic pump_up,
    input logic pump_dn,
    input logic drive_en,
    input logic lock_n
);
    // R3: overlap lasts one cycle at most
    a_r3_no_overlap: assert property (@(posedge clk) disable iff (rst)
        (pump_up && pump_dn) |=> !(pump_up && pump_dn));

    // R7: no drive while lock is held
    a_r7_quiet_in_lock: assert property (@(posedge clk) disable iff (rst)
        !lock_n |-> !drive_en);

    // R7: drive only accompanies a pump request
    a_r7_drive_needs_pump: assert property (@(posedge clk) disable iff (rst)
        drive_en |-> (pump_up || pump_dn));

    // R5: lock is only taken right after a finished comparison
    a_r5_lock_after_compare: assert property (@(posedge clk) disable iff (rst)
        $fell(lock_n) |-> $past(pump_up && pump_dn));

    // R8: reset state
    a_r8_reset_state: assert property (@(posedge clk)
        rst |=> (!pump_up && !pump_dn && !drive_en && lock_n));
endmodule

bind pfd_lock_detect pfd_lock_detect_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .pump_up  (pump_up),
    .pump_dn  (pump_dn),
    .drive_en (drive_en),
    .lock_n   (lock_n)
);

// File: tb/pfd_lock_detect_tb.sv
module pfd_lock_detect_tb;
    localparam int CLK_PERIOD = 10;
    localparam int PER        = 40;   // cycles per divided period
    localparam int HIGH       = 10;   // high time of each stream
    localparam int WATCHDOG   = 190000;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       vco_div = 1'b0;
    logic       ref_div = 1'b0;
    logic [3:0] lock_win = 4'd0;
    logic       pump_up, pump_dn, drive_en, lock_n;

    int checks = 0;
    int errors = 0;
    int up_cnt, dn_cnt, drv_cnt;
    int cyc = 0;
    bit done = 1'b0;

    pfd_lock_detect u_dut (
        .clk      (clk),
        .rst      (rst),
        .vco_div  (vco_div),
        .ref_div  (ref_div),
        .lock_win (lock_win),
        .pump_up  (pump_up),
        .pump_dn  (pump_dn),
        .drive_en (drive_en),
        .lock_n   (lock_n)
    );

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d (win=%0d)", req, act, exp, lock_win);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; vco_div = 1'b0; ref_div = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
    endtask

    // One divided period; leader rises at cycle 0, follower at cycle d.
    // Counts pump and drive cycles sampled at the falling edge.
    task automatic one_period(input int d, input bit vco_lead, input bit only_vco);
        up_cnt = 0; dn_cnt = 0; drv_cnt = 0;
        for (int i = 0; i < PER; i++) begin
            @(negedge clk);
            up_cnt  += int'(pump_up);
            dn_cnt  += int'(pump_dn);
            drv_cnt += int'(drive_en);
            if (only_vco) begin
                vco_div = (i < HIGH);
                ref_div = 1'b0;
            end else if (vco_lead) begin
                vco_div = (i < HIGH);
                ref_div = (i >= d) && (i < d + HIGH);
            end else begin
                ref_div = (i < HIGH);
                vco_div = (i >= d) && (i < d + HIGH);
            end
        end
    endtask

    initial begin
        wait (done || cyc >= WATCHDOG);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: actual %0d expected <%0d cycles", cyc, WATCHDOG);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        // R8: reset state, during and right after reset
        repeat (2) @(negedge clk);
        check("R8 up in reset", int'(pump_up), 0);
        check("R8 lock_n in reset", int'(lock_n), 1);
        rst = 1'b0;
        @(negedge clk);
        check("R8 up after reset", int'(pump_up), 0);
        check("R8 dn after reset", int'(pump_dn), 0);
        check("R8 drive after reset", int'(drive_en), 0);
        check("R8 lock_n after reset", int'(lock_n), 1);

        // Sweep every window against offsets in both directions (R1 R2 R4 R5 R7)
        for (int w = 0; w < 16; w++) begin
            for (int d = 0; d < 18; d++) begin
                for (int dir = 0; dir < 2; dir++) begin
                    bit inwin;
                    int tot_up, tot_dn;
                    lock_win = 4'(w);
                    do_reset();
                    inwin = (d <= w);
                    tot_up = 0; tot_dn = 0;
                    for (int p = 0; p < 3; p++) begin
                        one_period(d, dir == 0, 1'b0);
                        tot_up += up_cnt; tot_dn += dn_cnt;
                    end
                    check("R5 no lock after three", int'(lock_n), 1);
                    one_period(d, dir == 0, 1'b0);
                    tot_up += up_cnt; tot_dn += dn_cnt;
                    if (dir == 0) begin
                        check("R1 up cycles", tot_up, 4 * (d + 1));
                        check("R1 dn cycles", tot_dn, 4);
                    end else begin
                        check("R2 dn cycles", tot_dn, 4 * (d + 1));
                        check("R2 up cycles", tot_up, 4);
                    end
                    check("R4 R5 lock after four", int'(lock_n), inwin ? 0 : 1);
                    one_period(d, dir == 0, 1'b0);
                    check("R7 drive cycles", drv_cnt, inwin ? 0 : d + 1);
                end
            end
        end

        // R6: an outlying comparison breaks lock and restarts the run
        lock_win = 4'd3;
        do_reset();
        for (int p = 0; p < 4; p++) one_period(2, 1'b1, 1'b0);
        check("R6 locked before outlier", int'(lock_n), 0);
        one_period(6, 1'b1, 1'b0);
        check("R6 released by outlier", int'(lock_n), 1);
        for (int p = 0; p < 3; p++) one_period(2, 1'b1, 1'b0);
        check("R6 count restarted", int'(lock_n), 1);
        one_period(2, 1'b1, 1'b0);
        check("R6 relocked", int'(lock_n), 0);
        // R6: release while an edge is still pending (early miss)
        one_period(5, 1'b0, 1'b0);
        check("R6 released on late edge", int'(lock_n), 1);

        // R9: only the VCO stream toggles
        lock_win = 4'd15;
        do_reset();
        for (int p = 0; p < 3; p++) one_period(0, 1'b1, 1'b1);
        check("R9 up held", int'(pump_up), 1);
        check("R9 dn low", int'(pump_dn), 0);
        check("R9 lock released", int'(lock_n), 1);
        check("R9 drive on", int'(drive_en), 1);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule